// File: doc/BRIEF.md
# Edge/Level Interrupt Capture Core

This block gathers a vector of interrupt source lines and turns them into a small set of parent interrupt lines. Each source line is configured to be edge-sensitive or level-sensitive. Every source is first synchronised. Per source, the block then keeps three bits: the level sampled in the previous cycle, a pending bit and an in-service bit. A source whose sampled level differs from its previous sample records an event. Events are served one per cycle, lowest index first.

Serving a rising event can raise the source: it must be pending and unmasked. The source then becomes in service, and the parent line chosen by its vector entry goes high. Serving a falling event can retire the source: it must be in service and no longer pending. Its in-service bit then drops, and the chosen parent line goes low. In edge mode a falling input does not remove pending. Software removes it with the clear strobe, which acts only on edge-mode sources.

The block sits behind a register decoder. That decoder supplies the mask writes, the edge-select vector, the vector table and the clear strobe, and it reads back the status vector.

Top module: `irq_capture_core`

## Requirements
- R1: Reset clears the pending, in-service, previous-level and event state, sets every mask bit to 1 and drives every parent line low. As a result, no source can raise a parent line until its mask bit is written to 0.
- R2: A source line passes through a SYNC_STAGES-flop synchroniser. An edge-mode source (edge_i bit = 1) becomes pending only when its sampled level is 1 and its previous sampled level was 0.
- R3: For an edge-mode source, a sampled level of 0 updates only the previous-level bit. Its pending bit stays set until the clear strobe hits it.
- R4: For a level-mode source (edge_i bit = 0), pending follows the sampled level each cycle. It is set while the level is 1 and cleared while it is 0.
- R5: Serving a rising event on source i sets its in-service bit only when i is pending and its mask bit is 0. When it does, parent line vec(i) is driven to 1. A masked source causes no change.
- R6: Serving a falling event on source i clears its in-service bit and drives parent line vec(i) to 0 only when i is in service and not pending. The mask does not take part in this decision.
- R7: An event is served in the cycle after the one in which it is recorded. At most one event is served per cycle, the lowest-indexed one first. No more than one parent line and one in-service bit change in a cycle, except that a clear may drop several in-service bits.
- R8: vec(i) is the 8-bit field vec_i[8*i+7 : 8*i] taken modulo NOUT.
- R9: status_o equals the in-service vector AND NOT the mask vector.
- R10: A cycle with clr_i = 1 affects only the sources whose clr_bits_i bit and edge_i bit are both 1. For those sources it clears pending and in-service. Of those that were in service, only the lowest-indexed one drives its parent line to 0. Level-mode bits are ignored. No event is served in that cycle, and events are held for later.
- R11: A cycle with mask_we_i = 1 loads mask_wd_i into the mask. The write changes no parent line by itself; it only affects later evaluations and the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Asynchronous interrupt source lines |
| edge_i | input | NSRC | Per-source mode: 1 = edge, 0 = level |
| vec_i | input | 8*NSRC | Per-source 8-bit parent selector, source i in bits 8*i+7:8*i |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wd_i | input | NSRC | Mask value loaded on a write, 1 = masked |
| clr_i | input | 1 | Clear strobe |
| clr_bits_i | input | NSRC | Sources addressed by the clear strobe |
| par_o | output | NOUT | Parent interrupt lines |
| status_o | output | NSRC | In-service AND NOT mask |

## Verification
The bench builds the core with NSRC = 8 and NOUT = 3. Because three is not a power of two, vector entries from 0 to 9 show the modulo wrap of the routing. Eight sources are few enough that simultaneous changes on neighbouring lines, multi-bit clears and a mix of edge and level lanes occur often in the random phase. Directed sequences cover several cases:
- serving order across two lines that change in the same cycle;
- a clear that drops two in-service bits but lowers only one parent line;
- a masked source that becomes pending;
- a mask raised over a source that is already in service.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  localparam int unsigned VEC_W = 8;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_RAISE = 2'd1,
    ACT_LOWER = 2'd2
  } steer_act_e;
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/irq_lane_state.sv
module irq_lane_state #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl_i,
  input  logic [NSRC-1:0] edge_i,
  input  logic [NSRC-1:0] clr_hit_i,
  output logic [NSRC-1:0] last_o,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] chg_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_lane
    logic last_q, last_n, last_en;
    logic pend_q, pend_n, pend_en;

    always_comb begin
      last_n = lvl_i[g];
      if (clr_hit_i[g])    pend_n = 1'b0;
      else if (edge_i[g])  pend_n = pend_q | (lvl_i[g] & ~last_q);
      else                 pend_n = lvl_i[g];
      last_en = (last_n != last_q);
      pend_en = (pend_n != pend_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (last_en) last_q <= last_n;
        if (pend_en) pend_q <= pend_n;
      end
    end

    assign last_o[g] = last_q;
    assign pend_o[g] = pend_q;
    assign chg_o[g]  = lvl_i[g] ^ last_q;

    // R3
    edge_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && edge_i[g] && !clr_hit_i[g]) |=> pend_q);

    // R2
    edge_set_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && edge_i[g] && !(lvl_i[g] && !last_q)) |=> !pend_q);
  end
endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int unsigned W = 8,
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             hit_o
);
  always_comb begin
    idx_o = '0;
    hit_o = 1'b0;
    for (int k = W - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        idx_o = IDX_W'(k);
        hit_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_out_steer.sv
module irq_out_steer
  import irq_cap_pkg::*;
#(
  parameter int unsigned NSRC = 8,
  parameter int unsigned NOUT = 4,
  localparam int unsigned IDX_W = $clog2(NSRC),
  localparam int unsigned OUT_W = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  steer_act_e            act_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [NSRC*VEC_W-1:0] vec_i,
  output logic [NOUT-1:0]       par_o
);
  logic [VEC_W-1:0] vsel;
  logic [OUT_W-1:0] tgt;
  logic [NOUT-1:0]  par_q, par_n;
  logic             par_en;

  assign vsel = vec_i[idx_i*VEC_W +: VEC_W];
  assign tgt  = OUT_W'(int'(vsel) % NOUT);

  always_comb begin
    par_n  = par_q;
    par_en = 1'b0;
    case (act_i)
      ACT_RAISE: begin par_n[tgt] = 1'b1; par_en = 1'b1; end
      ACT_LOWER: begin par_n[tgt] = 1'b0; par_en = 1'b1; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      par_q <= '0;
    else if (par_en) par_q <= par_n;
  end

  assign par_o = par_q;

  // R7
  one_par_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(par_q ^ $past(par_q)) <= 1));
endmodule

// File: rtl/irq_capture_core.sv
module irq_capture_core
  import irq_cap_pkg::*;
#(
  parameter int unsigned NSRC        = 64,
  parameter int unsigned NOUT        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       src_i,
  input  logic [NSRC-1:0]       edge_i,
  input  logic [NSRC*VEC_W-1:0] vec_i,
  input  logic                  mask_we_i,
  input  logic [NSRC-1:0]       mask_wd_i,
  input  logic                  clr_i,
  input  logic [NSRC-1:0]       clr_bits_i,
  output logic [NOUT-1:0]       par_o,
  output logic [NSRC-1:0]       status_o
);
  logic [NSRC-1:0]  lvl, last_q, pend_q, chg, clr_hit;
  logic [NSRC-1:0]  evt_q, evt_n, evt_keep;
  logic [NSRC-1:0]  isr_q, isr_n;
  logic [NSRC-1:0]  mask_q;
  logic [IDX_W-1:0] e_idx, c_idx, sel_idx;
  logic             e_hit, c_hit;
  steer_act_e       act;

  irq_sync_bank #(.W(NSRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(lvl)
  );

  assign clr_hit = clr_i ? (clr_bits_i & edge_i) : '0;

  irq_lane_state #(.NSRC(NSRC)) i_lanes (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .edge_i(edge_i),
    .clr_hit_i(clr_hit), .last_o(last_q), .pend_o(pend_q), .chg_o(chg)
  );

  irq_lsb_pick #(.W(NSRC)) i_evt_pick (
    .req_i(evt_q), .idx_o(e_idx), .hit_o(e_hit)
  );

  irq_lsb_pick #(.W(NSRC)) i_clr_pick (
    .req_i(clr_hit & isr_q), .idx_o(c_idx), .hit_o(c_hit)
  );

  always_comb begin
    act      = ACT_IDLE;
    sel_idx  = e_idx;
    isr_n    = isr_q;
    evt_keep = evt_q;
    if (clr_i) begin
      isr_n = isr_q & ~clr_hit;
      if (c_hit) begin
        act     = ACT_LOWER;
        sel_idx = c_idx;
      end
    end else if (e_hit) begin
      evt_keep[e_idx] = 1'b0;
      if (last_q[e_idx]) begin
        if (pend_q[e_idx] && !mask_q[e_idx]) begin
          act          = ACT_RAISE;
          isr_n[e_idx] = 1'b1;
        end
      end else if (isr_q[e_idx] && !pend_q[e_idx]) begin
        act          = ACT_LOWER;
        isr_n[e_idx] = 1'b0;
      end
    end
    evt_n = evt_keep | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      isr_q  <= '0;
      mask_q <= '1;
    end else begin
      evt_q <= evt_n;
      isr_q <= isr_n;
      if (mask_we_i) mask_q <= mask_wd_i;
    end
  end

  irq_out_steer #(.NSRC(NSRC), .NOUT(NOUT)) i_steer (
    .clk(clk), .rst_n(rst_n), .act_i(act), .idx_i(sel_idx),
    .vec_i(vec_i), .par_o(par_o)
  );

  assign status_o = isr_q & ~mask_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    // R5
    isr_set_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!isr_q[g] && !(pend_q[g] && !mask_q[g])) |=> !isr_q[g]);
  end

  // R7
  one_isr_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ($countones(isr_q ^ $past(isr_q)) <= 1));

  // R10
  clr_drops_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((isr_q & $past(clr_bits_i & edge_i)) == '0));
endmodule

// File: tb/test_irq_capture_core.sv
module test_irq_capture_core;
  localparam int CLK_P = 10;
  localparam int NS = 8;
  localparam int NO = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] src = '0, edge_cfg = 8'h0F, mask_wd = '0, clr_bits = '0;
  logic mask_we = 1'b0, clr_s = 1'b0;
  logic [NS*8-1:0] vec_cfg = {8'd9, 8'd2, 8'd7, 8'd0, 8'd4, 8'd5, 8'd1, 8'd0};
  logic [NO-1:0] par_o;
  logic [NS-1:0] status_o;
  int nchk = 0, nerr = 0;
  bit run = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_capture_core #(.NSRC(NS), .NOUT(NO), .SYNC_STAGES(2)) i_irq_capture_core (
    .clk(clk), .rst_n(rst_n), .src_i(src), .edge_i(edge_cfg), .vec_i(vec_cfg),
    .mask_we_i(mask_we), .mask_wd_i(mask_wd), .clr_i(clr_s), .clr_bits_i(clr_bits),
    .par_o(par_o), .status_o(status_o)
  );

  // behavioural reference model
  logic [NS-1:0] m_s1, m_s2, m_last, m_pend, m_isr, m_evt, m_mask;
  logic [NO-1:0] m_par;

  function automatic int tgt(int i);
    return int'(vec_cfg[i*8 +: 8]) % NO;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [NS-1:0] lvl, n_isr, n_evt, n_pend, cb;
    logic [NO-1:0] n_par;
    int sel;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_last = '0; m_pend = '0; m_isr = '0;
      m_evt = '0; m_mask = '1; m_par = '0;
    end else begin
      lvl = m_s2; n_isr = m_isr; n_par = m_par; n_evt = m_evt;
      cb = clr_bits & edge_cfg;
      sel = -1;
      if (clr_s) begin
        for (int k = NS - 1; k >= 0; k--) if (cb[k] && m_isr[k]) sel = k;
        if (sel >= 0) n_par[tgt(sel)] = 1'b0;
        n_isr = m_isr & ~cb;
      end else begin
        for (int k = NS - 1; k >= 0; k--) if (m_evt[k]) sel = k;
        if (sel >= 0) begin
          n_evt[sel] = 1'b0;
          if (m_last[sel]) begin
            if (m_pend[sel] && !m_mask[sel]) begin
              n_isr[sel] = 1'b1; n_par[tgt(sel)] = 1'b1;
            end
          end else if (m_isr[sel] && !m_pend[sel]) begin
            n_isr[sel] = 1'b0; n_par[tgt(sel)] = 1'b0;
          end
        end
      end
      for (int i = 0; i < NS; i++) begin
        if (edge_cfg[i]) n_pend[i] = m_pend[i] | (lvl[i] & ~m_last[i]);
        else             n_pend[i] = lvl[i];
        if (clr_s && cb[i]) n_pend[i] = 1'b0;
      end
      n_evt = n_evt | (lvl ^ m_last);
      m_last = lvl; m_pend = n_pend; m_isr = n_isr; m_par = n_par; m_evt = n_evt;
      if (mask_we) m_mask = mask_wd;
      m_s2 = m_s1; m_s1 = src;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      nchk++;
      if (par_o !== m_par) begin
        nerr++;
        $display("FAIL R5/R6/R7 model par_o: actual=%b expected=%b at %0t", par_o, m_par, $time);
      end
      nchk++;
      if (status_o !== (m_isr & ~m_mask)) begin
        nerr++;
        $display("FAIL R9 model status_o: actual=%h expected=%h at %0t",
                 status_o, m_isr & ~m_mask, $time);
      end
    end
  end

  task automatic chk(string tag, logic [NO-1:0] ep, logic [NS-1:0] es);
    nchk++;
    if (par_o !== ep || status_o !== es) begin
      nerr++;
      $display("FAIL %s: actual par=%b status=%h expected par=%b status=%h",
               tag, par_o, status_o, ep, es);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wmask(logic [NS-1:0] v);
    mask_we = 1'b1; mask_wd = v;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic do_clr(logic [NS-1:0] v);
    clr_s = 1'b1; clr_bits = v;
    @(negedge clk);
    clr_s = 1'b0; clr_bits = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs low", 3'b000, 8'h00);
    src[0] = 1'b1; settle();
    chk("R1 mask set at reset blocks raise", 3'b000, 8'h00);
    wmask(8'h00); settle();
    chk("R11 mask write alone changes no output", 3'b000, 8'h00);
    src[0] = 1'b0; settle();
    src[0] = 1'b1; settle();
    chk("R2/R5 edge rise raises parent 0", 3'b001, 8'h01);
    src[0] = 1'b0; settle();
    chk("R3 edge fall keeps pending and output", 3'b001, 8'h01);
    do_clr(8'h01); settle();
    chk("R10 clear retires edge source", 3'b000, 8'h00);
    src[4] = 1'b1; settle();
    chk("R4/R5 level high raises parent 0", 3'b001, 8'h10);
    do_clr(8'h10); settle();
    chk("R10 clear ignored on level source", 3'b001, 8'h10);
    src[4] = 1'b0; settle();
    chk("R6 level low lowers parent", 3'b000, 8'h00);
    src[2] = 1'b1; settle();
    chk("R8 vector 5 wraps to parent 2", 3'b100, 8'h04);
    do_clr(8'h04); src[2] = 1'b0; settle();
    chk("R10 clear source 2", 3'b000, 8'h00);
    wmask(8'h08); src[3] = 1'b1; settle();
    chk("R5 masked source not raised", 3'b000, 8'h00);
    wmask(8'h00); settle();
    chk("R11 unmask triggers no evaluation", 3'b000, 8'h00);
    do_clr(8'h08); src[3] = 1'b0; settle();
    // ordering: two level lines change together
    src[5:4] = 2'b11;
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R7 lower index served first", 3'b001, 8'h10);
    @(negedge clk);
    chk("R7 second served next cycle", 3'b011, 8'h30);
    settle();
    src[5:4] = 2'b00;
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R7 lower index retired first", 3'b010, 8'h20);
    @(negedge clk);
    chk("R7 second retired next cycle", 3'b000, 8'h00);
    src[6] = 1'b1; settle();
    chk("R8 source 6 to parent 2", 3'b100, 8'h40);
    wmask(8'h40); settle();
    chk("R9 masked in-service hidden from status", 3'b100, 8'h00);
    src[6] = 1'b0; settle();
    chk("R6 lower ignores mask", 3'b000, 8'h00);
    wmask(8'h00);
    src[1:0] = 2'b11; settle();
    chk("R5 two edge sources raised", 3'b011, 8'h03);
    src[1:0] = 2'b00; settle();
    do_clr(8'h03); settle();
    chk("R10 only lowest cleared source lowers", 3'b010, 8'h00);
    src[1] = 1'b1; settle();
    chk("R2 re-rise after clear raises again", 3'b010, 8'h02);
    do_clr(8'h02); src[1] = 1'b0; settle();
    chk("R10 clear source 1", 3'b000, 8'h00);
    // random phase against the model
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 30) src[$urandom_range(0, NS - 1)] ^= 1'b1;
      if (r >= 90) begin clr_s = 1'b1; clr_bits = NS'($urandom); end
      else begin clr_s = 1'b0; clr_bits = '0; end
      if (r == 50) begin mask_we = 1'b1; mask_wd = NS'($urandom) & NS'($urandom); end
      else mask_we = 1'b0;
      if (r == 77 && (c % 7) == 0) edge_cfg = NS'($urandom);
      @(negedge clk);
    end
    clr_s = 1'b0; mask_we = 1'b0; src = '0;
    settle();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule